// File: doc/BRIEF.md
# Performance Event to Counter Mapper

This block sits between the event sources of a processor core and its bank of programmable performance counters. Software chooses what a counter measures by writing that counter's event-select register. The mapper watches those writes and keeps a small table that ties each supported hardware event to at most one counter. At run time, event sources present a one-cycle pulse tagged with a 20-bit event identifier. The mapper looks the identifier up and raises the increment line of the counter it is mapped to. Pulses that match no mapping are discarded and flagged.

The table has one entry per supported event, and each entry holds a valid bit and a counter index. A write is accepted only when it targets a programmable counter that is present in the build and carries one of five encoded events. A write of all zeros to a counter removes every mapping that points to that counter. The block also answers a combinational query that the counter logic uses to decide whether a counter tracks cycles or retired instructions. The fixed counters at index 0 (cycles) and index 2 (instructions) always report yes for their own event.

Top module: `perf_event_mapper`

## Requirements
- R1: After reset every table entry is invalid, `inc_vec`, `evt_drop` and `cfg_wr_err` are low, and the query reports cycles only for counter 0 and instructions only for counter 2.
- R2: The event index of a write is bits 19:16 (type) and 15:0 (code) of `cfg_wr_val`. For type 1 the code splits into cache id in bits 15:3, operation in bits 2:1 and a miss flag in bit 0. Only 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data TLB read miss), 0x1001B (data TLB write miss) and 0x10021 (instruction TLB miss) are accepted. A non-zero write of any other index pulses `cfg_wr_err` one cycle later and leaves the table unchanged.
- R3: A counter index is writable only when it is at least 3, below `NUM_CTRS` and its bit in `AVAIL_MASK` is set. A write to any other index, including a zero write, pulses `cfg_wr_err` and changes nothing.
- R4: An accepted write of an unmapped event maps that event to the written counter. The mapping takes effect for event pulses from the next cycle onward, and `cfg_wr_err` stays low.
- R5: A write of an event that is already mapped is ignored without error, and the existing mapping is kept.
- R6: A write whose whole `cfg_wr_val` is zero removes every mapping to that counter, keeps all other mappings, and raises no error.
- R7: An event pulse whose identifier is mapped sets exactly the mapped counter's bit of `inc_vec` for one cycle, one clock after the pulse.
- R8: An event pulse whose identifier is unmapped or unsupported leaves `inc_vec` at zero and pulses `evt_drop` one clock after the pulse.
- R9: `qry_is_cycles` is high when `qry_ctr` is 0 or equals the counter mapped to the cycles event.
- R10: `qry_is_instret` is high when `qry_ctr` is 2 or equals the counter mapped to the instructions event.
- R11: An event pulse presented in the same cycle as a configuration write is routed through the table as it stood before that write.
- R12: One counter may hold mappings for several events at once. Each of those events increments it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Event-select register write strobe |
| cfg_wr_ctr | input | CTR_W | Counter index being written |
| cfg_wr_val | input | SEL_W | Value written to the event-select register |
| cfg_wr_err | output | 1 | One-cycle pulse: the previous write was rejected |
| evt_valid | input | 1 | Event pulse present |
| evt_id | input | 20 | Identifier of the event pulse |
| inc_vec | output | NUM_CTRS | Per-counter increment strobes |
| evt_drop | output | 1 | One-cycle pulse: the previous event had no mapping |
| qry_ctr | input | CTR_W | Counter index being queried |
| qry_is_cycles | output | 1 | Queried counter tracks cycles |
| qry_is_instret | output | 1 | Queried counter tracks retired instructions |

## Verification
The bench sweeps every counter index against every supported event, plus a set of near-miss encodings. These include a clear miss flag, a wrong cache id, a wrong operation and a wrong type, and a value whose low 20 bits are zero while its upper bits are not. A decoder that ignored one field would accept one of these, and a zero test applied to the low 20 bits alone would take the last as an unmap. Remapping an already mapped event to another counter is checked, because a design that overwrote the entry would move the increments to the new counter. Unmapping a counter that holds two events is checked, because a design that cleared only the first match would leave one event still counting. A same-cycle write and event catches routing through the updated table, which would increment a counter that was just unmapped.

// File: rtl/pem_pkg.sv
package pem_pkg;

    localparam int EVT_W   = 20;
    localparam int NUM_EVT = 5;

    // first programmable counter and the two fixed counters
    localparam int FIRST_PROG = 3;
    localparam int FIXED_CYC  = 0;
    localparam int FIXED_INS  = 2;

    // table slots, one per supported event
    localparam int SLOT_CYC  = 0;
    localparam int SLOT_INS  = 1;
    localparam int SLOT_DRD  = 2;
    localparam int SLOT_DWR  = 3;
    localparam int SLOT_ITLB = 4;

    typedef struct packed {
        logic [3:0]  etype;
        logic [15:0] code;
    } evt_idx_t;

    typedef struct packed {
        logic [12:0] cache_id;
        logic [1:0]  op;
        logic        miss;
    } cache_code_t;

    localparam logic [3:0]  TYPE_GEN   = 4'd0;
    localparam logic [3:0]  TYPE_CACHE = 4'd1;
    localparam logic [15:0] CODE_CYC   = 16'd1;
    localparam logic [15:0] CODE_INS   = 16'd2;
    localparam logic [12:0] CID_DTLB   = 13'd3;
    localparam logic [12:0] CID_ITLB   = 13'd4;
    localparam logic [1:0]  OP_RD      = 2'd0;
    localparam logic [1:0]  OP_WR      = 2'd1;

endpackage

// File: rtl/pem_event_decode.sv
module pem_event_decode
    import pem_pkg::*;
(
    input  logic [EVT_W-1:0]   idx,
    output logic [NUM_EVT-1:0] slot_hit
);

    evt_idx_t    fld;
    cache_code_t cc;
    logic        is_cache_miss;

    always_comb begin
        fld           = evt_idx_t'(idx);
        cc            = cache_code_t'(fld.code);
        is_cache_miss = (fld.etype == TYPE_CACHE) && cc.miss;
        slot_hit      = '0;
        slot_hit[SLOT_CYC]  = (fld.etype == TYPE_GEN) && (fld.code == CODE_CYC);
        slot_hit[SLOT_INS]  = (fld.etype == TYPE_GEN) && (fld.code == CODE_INS);
        slot_hit[SLOT_DRD]  = is_cache_miss && (cc.cache_id == CID_DTLB) && (cc.op == OP_RD);
        slot_hit[SLOT_DWR]  = is_cache_miss && (cc.cache_id == CID_DTLB) && (cc.op == OP_WR);
        slot_hit[SLOT_ITLB] = is_cache_miss && (cc.cache_id == CID_ITLB) && (cc.op == OP_RD);
    end

endmodule

// File: rtl/pem_ctr_gate.sv
module pem_ctr_gate
    import pem_pkg::*;
#(
    parameter int                     NUM_CTRS   = 8,
    parameter int                     CTR_W      = 3,
    parameter logic [NUM_CTRS-1:0]    AVAIL_MASK = '1
) (
    input  logic [CTR_W-1:0] ctr,
    output logic             ok
);

    localparam int SPAN = 1 << CTR_W;

    logic [SPAN-1:0] usable;

    for (genvar i = 0; i < SPAN; i++) begin : g_use
        if (i < FIRST_PROG || i >= NUM_CTRS) begin : g_off
            assign usable[i] = 1'b0;
        end else begin : g_on
            assign usable[i] = AVAIL_MASK[i];
        end
    end

    assign ok = usable[ctr];

endmodule

// File: rtl/pem_table.sv
module pem_table
    import pem_pkg::*;
#(
    parameter int CTR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CTR_W-1:0]              wr_ctr,
    input  logic                          wr_ok,
    input  logic                          wr_zero,
    input  logic [NUM_EVT-1:0]            wr_hit,
    output logic [NUM_EVT-1:0]            ent_vld,
    output logic [NUM_EVT-1:0][CTR_W-1:0] ent_ctr,
    output logic                          wr_err
);

    typedef struct packed {
        logic [NUM_EVT-1:0]            vld;
        logic [NUM_EVT-1:0][CTR_W-1:0] ctr;
        logic                          err;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            if (!wr_ok) begin
                st_d.err = 1'b1;
            end else if (wr_zero) begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (st_q.vld[e] && (st_q.ctr[e] == wr_ctr)) begin
                        st_d.vld[e] = 1'b0;
                    end
                end
            end else if (wr_hit == '0) begin
                st_d.err = 1'b1;
            end else begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (wr_hit[e] && !st_q.vld[e]) begin
                        st_d.vld[e] = 1'b1;
                        st_d.ctr[e] = wr_ctr;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_vld = st_q.vld;
    assign ent_ctr = st_q.ctr;
    assign wr_err  = st_q.err;

    p_bad_ctr_keeps_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> ($stable(ent_vld) && $stable(ent_ctr)));

    p_err_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    p_unknown_keeps_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && !wr_zero && (wr_hit == '0)) |=> ($stable(ent_vld) && $stable(ent_ctr)));

    p_mapped_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && !wr_zero && ((wr_hit & ent_vld) != '0)) |=> $stable(ent_ctr));

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_chk
        p_unmap_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ok && wr_zero && ent_vld[e] && (ent_ctr[e] == wr_ctr)) |=> !ent_vld[e]);
    end

endmodule

// File: rtl/pem_router.sv
module pem_router
    import pem_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    parameter int CTR_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt_valid,
    input  logic [NUM_EVT-1:0]            evt_hit,
    input  logic [NUM_EVT-1:0]            ent_vld,
    input  logic [NUM_EVT-1:0][CTR_W-1:0] ent_ctr,
    output logic [NUM_CTRS-1:0]           inc_vec,
    output logic                          drop
);

    typedef struct packed {
        logic [NUM_CTRS-1:0] inc;
        logic                drop;
    } rt_t;

    rt_t rt_d, rt_q;
    logic [NUM_EVT-1:0] live;

    always_comb begin
        live      = evt_hit & ent_vld;
        rt_d      = '0;
        if (evt_valid) begin
            for (int c = 0; c < NUM_CTRS; c++) begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (live[e] && (ent_ctr[e] == CTR_W'(c))) begin
                        rt_d.inc[c] = 1'b1;
                    end
                end
            end
            rt_d.drop = (live == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign inc_vec = rt_q.inc;
    assign drop    = rt_q.drop;

    p_inc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_vec));

    p_inc_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_vec != '0) |-> $past(evt_valid));

    p_drop_excludes_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (inc_vec == '0));

    p_drop_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> $past(evt_valid));

endmodule

// File: rtl/perf_event_mapper.sv
module perf_event_mapper
    import pem_pkg::*;
#(
    parameter int                  NUM_CTRS   = 8,
    parameter int                  CTR_W      = $clog2(NUM_CTRS),
    parameter int                  SEL_W      = 32,
    parameter logic [NUM_CTRS-1:0] AVAIL_MASK = NUM_CTRS'('hD8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CTR_W-1:0]    cfg_wr_ctr,
    input  logic [SEL_W-1:0]    cfg_wr_val,
    output logic                cfg_wr_err,
    input  logic                evt_valid,
    input  logic [EVT_W-1:0]    evt_id,
    output logic [NUM_CTRS-1:0] inc_vec,
    output logic                evt_drop,
    input  logic [CTR_W-1:0]    qry_ctr,
    output logic                qry_is_cycles,
    output logic                qry_is_instret
);

    logic [NUM_EVT-1:0]            wr_hit;
    logic [NUM_EVT-1:0]            ev_hit;
    logic [NUM_EVT-1:0]            ent_vld;
    logic [NUM_EVT-1:0][CTR_W-1:0] ent_ctr;
    logic                          wr_ok;
    logic                          wr_zero;

    assign wr_zero = (cfg_wr_val == '0);

    pem_event_decode u_wr_dec (
        .idx      (cfg_wr_val[EVT_W-1:0]),
        .slot_hit (wr_hit)
    );

    pem_event_decode u_ev_dec (
        .idx      (evt_id),
        .slot_hit (ev_hit)
    );

    pem_ctr_gate #(
        .NUM_CTRS   (NUM_CTRS),
        .CTR_W      (CTR_W),
        .AVAIL_MASK (AVAIL_MASK)
    ) u_gate (
        .ctr (cfg_wr_ctr),
        .ok  (wr_ok)
    );

    pem_table #(
        .CTR_W (CTR_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_ctr  (cfg_wr_ctr),
        .wr_ok   (wr_ok),
        .wr_zero (wr_zero),
        .wr_hit  (wr_hit),
        .ent_vld (ent_vld),
        .ent_ctr (ent_ctr),
        .wr_err  (cfg_wr_err)
    );

    pem_router #(
        .NUM_CTRS (NUM_CTRS),
        .CTR_W    (CTR_W)
    ) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_hit   (ev_hit),
        .ent_vld   (ent_vld),
        .ent_ctr   (ent_ctr),
        .inc_vec   (inc_vec),
        .drop      (evt_drop)
    );

    // monitor query: fixed counters always answer for their own event
    always_comb begin
        qry_is_cycles  = (qry_ctr == CTR_W'(FIXED_CYC)) ||
                         (ent_vld[SLOT_CYC] && (ent_ctr[SLOT_CYC] == qry_ctr));
        qry_is_instret = (qry_ctr == CTR_W'(FIXED_INS)) ||
                         (ent_vld[SLOT_INS] && (ent_ctr[SLOT_INS] == qry_ctr));
    end

    p_fixed_cycles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_ctr == CTR_W'(FIXED_CYC)) |-> qry_is_cycles);

    p_fixed_instret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_ctr == CTR_W'(FIXED_INS)) |-> qry_is_instret);

    p_accept_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && wr_ok && (wr_zero || (wr_hit != '0))) |=> !cfg_wr_err);

endmodule

// File: tb/perf_event_mapper_tb.sv
module perf_event_mapper_tb;

    localparam int NC = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [CW-1:0] cfg_wr_ctr = '0;
    logic [31:0]   cfg_wr_val = '0;
    logic          cfg_wr_err;
    logic          evt_valid = 1'b0;
    logic [19:0]   evt_id = '0;
    logic [NC-1:0] inc_vec;
    logic          evt_drop;
    logic [CW-1:0] qry_ctr = '0;
    logic          qry_is_cycles;
    logic          qry_is_instret;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit exp_vld [5];
    int exp_ctr [5];

    always #10 clk = ~clk;

    perf_event_mapper u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_ctr     (cfg_wr_ctr),
        .cfg_wr_val     (cfg_wr_val),
        .cfg_wr_err     (cfg_wr_err),
        .evt_valid      (evt_valid),
        .evt_id         (evt_id),
        .inc_vec        (inc_vec),
        .evt_drop       (evt_drop),
        .qry_ctr        (qry_ctr),
        .qry_is_cycles  (qry_is_cycles),
        .qry_is_instret (qry_is_instret)
    );

    function automatic int slot_of(logic [19:0] id);
        case (id)
            20'h00001: return 0;
            20'h00002: return 1;
            20'h10019: return 2;
            20'h1001B: return 3;
            20'h10021: return 4;
            default:   return -1;
        endcase
    endfunction

    function automatic bit ctr_ok(int c);
        return (c >= 3) && (c < NC) && (c != 5);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock step with an optional write and an optional event
    task automatic step(string tag, bit do_wr, int c, logic [31:0] val, bit do_ev, logic [19:0] id);
        logic [NC-1:0] e_inc;
        bit            e_drop;
        bit            e_err;
        int            s;
        e_inc  = '0;
        e_drop = 0;
        e_err  = 0;
        if (do_ev) begin
            s = slot_of(id);
            if (s >= 0 && exp_vld[s]) e_inc[exp_ctr[s]] = 1'b1;
            else e_drop = 1;
        end
        if (do_wr) begin
            if (!ctr_ok(c)) begin
                e_err = 1;
            end else if (val == 32'h0) begin
                for (int e = 0; e < 5; e++) if (exp_vld[e] && exp_ctr[e] == c) exp_vld[e] = 0;
            end else begin
                s = slot_of(val[19:0]);
                if (s < 0) e_err = 1;
                else if (!exp_vld[s]) begin exp_vld[s] = 1; exp_ctr[s] = c; end
            end
        end
        @(negedge clk);
        cfg_wr_en  = do_wr;
        cfg_wr_ctr = CW'(c);
        cfg_wr_val = val;
        evt_valid  = do_ev;
        evt_id     = id;
        @(negedge clk);
        if (do_wr) check({tag, " write error flag"}, cfg_wr_err, e_err);
        if (do_ev) begin
            check({tag, " R7 increment vector"}, inc_vec, e_inc);
            check({tag, " R8 drop flag"}, evt_drop, e_drop);
        end
        cfg_wr_en = 0;
        evt_valid = 0;
    endtask

    task automatic query_sweep(string tag);
        for (int c = 0; c < NC; c++) begin
            bit ec, ei;
            ec = (c == 0) || (exp_vld[0] && exp_ctr[0] == c);
            ei = (c == 2) || (exp_vld[1] && exp_ctr[1] == c);
            qry_ctr = CW'(c);
            #2;
            check({tag, " R9 cycles query"}, qry_is_cycles, ec);
            check({tag, " R10 instret query"}, qry_is_instret, ei);
        end
    endtask

    task automatic event_sweep(string tag);
        logic [19:0] ids [9] = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021,
                                 20'h00000, 20'h10018, 20'h20001, 20'hFFFFF};
        for (int k = 0; k < 9; k++) step(tag, 0, 0, 32'h0, 1, ids[k]);
    endtask

    task automatic unmap_all();
        for (int c = 3; c < NC; c++) step("R6 clear", 1, c, 32'h0, 0, 20'h0);
    endtask

    initial begin
        for (int e = 0; e < 5; e++) begin exp_vld[e] = 0; exp_ctr[e] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 inc_vec", inc_vec, 0);
        check("R1 evt_drop", evt_drop, 0);
        check("R1 cfg_wr_err", cfg_wr_err, 0);
        query_sweep("R1");
        event_sweep("R1 empty table");

        // R3: invalid counters, including zero writes
        step("R3", 1, 0, 32'h1, 0, 20'h0);
        step("R3", 1, 1, 32'h2, 0, 20'h0);
        step("R3", 1, 2, 32'h1, 0, 20'h0);
        step("R3", 1, 5, 32'h1, 0, 20'h0);
        step("R3", 1, 1, 32'h0, 0, 20'h0);
        query_sweep("R3");

        // R2: near-miss encodings rejected, upper bits ignored
        step("R2", 1, 3, 32'h00003, 0, 20'h0);
        step("R2", 1, 3, 32'h10018, 0, 20'h0);
        step("R2", 1, 3, 32'h10011, 0, 20'h0);
        step("R2", 1, 3, 32'h1001D, 0, 20'h0);
        step("R2", 1, 3, 32'h20001, 0, 20'h0);
        step("R2", 1, 3, 32'h00100000, 0, 20'h0);
        query_sweep("R2");

        // R4, R12: map all five, two onto counter 6
        step("R4", 1, 3, 32'hFFF00001, 0, 20'h0);
        step("R4", 1, 4, 32'h00002, 0, 20'h0);
        step("R12", 1, 6, 32'h10019, 0, 20'h0);
        step("R4", 1, 7, 32'h1001B, 0, 20'h0);
        step("R12", 1, 6, 32'h10021, 0, 20'h0);
        event_sweep("R12 mapped");
        query_sweep("R4");

        // R5: remap attempt ignored
        step("R5", 1, 7, 32'h00001, 0, 20'h0);
        step("R5", 1, 3, 32'h10019, 0, 20'h0);
        event_sweep("R5");
        query_sweep("R5");

        // R6: unmap counter holding two events, and an empty counter
        step("R6", 1, 6, 32'h0, 0, 20'h0);
        step("R6", 1, 6, 32'h0, 0, 20'h0);
        event_sweep("R6");
        step("R6", 1, 7, 32'h10021, 0, 20'h0);
        event_sweep("R6 remap");

        // R11: same-cycle write and event
        step("R11", 1, 4, 32'h0, 1, 20'h00002);
        step("R11", 0, 0, 32'h0, 1, 20'h00002);
        step("R11", 1, 4, 32'h00002, 1, 20'h00002);
        step("R11", 0, 0, 32'h0, 1, 20'h00002);

        // sweep every counter against every supported event
        for (int c = 0; c < NC; c++) begin
            logic [31:0] vals [5] = '{32'h00001, 32'h00002, 32'h10019, 32'h1001B, 32'h10021};
            for (int k = 0; k < 5; k++) begin
                unmap_all();
                step("R4 sweep", 1, c, vals[k], 0, 20'h0);
                step("R7 sweep", 0, 0, 32'h0, 1, vals[k][19:0]);
                query_sweep("R9 sweep");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule